// File: doc/BRIEF.md
# Second-Order Sigma-Delta Modulator (Digital Model)

This block is a cycle-accurate fixed-point model of a second-order, single-bit sigma-delta modulator. On every clock cycle where the enable is high it performs one oversampling update. A signed input sample is clamped to the allowed input range and fed into two cascaded accumulating integrators. The sign of the second integrator is the one-bit decision, and that decision is fed back into both integrators through fixed coefficients. The block presents the decision as a bit and also as its signed bipolar value.

Full scale (the rail) is the value 2^(F-1). The input is limited to 80 % of the rail, and both integrators clamp at the rail. Constant coefficient multiplies use rounded reciprocal constants with Q fractional bits.

A bypass input replaces the quantizer with unity gain. In bypass mode the feedback is the second integrator's raw value and the value output shows that integrator, so its settling can be watched directly.

Top module: `sd2_modulator`

## Requirements
- R1: A synchronous reset clears both integrators to zero. After reset, with bypass low, bit_out is 0 and val_out is -2^(F-1). With bypass high, val_out is 0.
- R2: The input is clamped before use to the range [-L, +L], where L = floor(4·2^(F-1)/5).
- R3: Every coefficient product is computed as floor((v·K + 2^(Q-1)) / 2^Q). Here K is round(2^Q/5) for the one-fifth terms, round(2^Q/3) for the one-third terms and round(2^Q/6) for the one-sixth term.
- R4: On an enabled update, the first integrator adds (x/5 − y/5), where x is the clamped input and y is the feedback value.
- R5: On an enabled update, the second integrator adds (x/3 + s1/3 − y/6), where s1 is the first integrator's value before the update.
- R6: bit_out is 1 exactly when the second integrator is strictly positive. In normal mode the feedback and val_out are +2^(F-1) when bit_out is 1 and −2^(F-1) when it is 0.
- R7: After each update, each integrator is saturated to the range [−2^(F-1), +2^(F-1)].
- R8: When en is low, neither integrator changes.
- R9: With bypass high, the feedback value y is the second integrator's value, and val_out equals that value.
- R10: For a constant input in normal mode, the mean of val_out over 49152 updates is within 2^(F-1)/4096 of the clamped input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable, one pulse per oversampled sample |
| bypass | input | 1 | Replaces the quantizer with unity gain |
| x_in | input | F+1 | Signed input sample |
| bit_out | output | 1 | One-bit decision (1 means +rail) |
| val_out | output | F+1 | Signed bipolar decision, or the second integrator value in bypass |

## Verification
Integrator saturation is the hardest condition to reach from the ports. A legal input near the limit settles well inside the rail in normal operation. The bench therefore drives bypass mode with a square wave at ±L whose half-period of 12 updates matches the ringing of the unquantized loop. This pumps energy into the loop until the reference model records clamping events. The same stimulus also exercises R9. The bench then checks that the long-run average of the bit stream tracks DC inputs of both signs, with the modulator starting from reset each time.

// File: rtl/sd2_modulator.sv
module sd2_modulator #(
  parameter int F = 20,
  parameter int Q = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               bypass,
  input  logic signed [F:0]  x_in,
  output logic               bit_out,
  output logic signed [F:0]  val_out
);
  localparam int DW = F + 1;
  localparam int SW = F + 4;
  localparam int PW = SW + Q + 2;
  localparam longint K5 = ((longint'(1) << (Q + 1)) + 5) / 10;
  localparam longint K3 = ((longint'(1) << (Q + 1)) + 3) / 6;
  localparam longint K6 = ((longint'(1) << (Q + 1)) + 6) / 12;
  localparam longint LIMI = ((longint'(1) << (F - 1)) * 4) / 5;
  localparam logic signed [SW-1:0] FS   = {{(SW-F){1'b0}}, 1'b1, {(F-1){1'b0}}};
  localparam logic signed [SW-1:0] NFS  = -FS;
  localparam logic signed [SW-1:0] LIM  = SW'(LIMI);
  localparam logic signed [SW-1:0] NLIM = -LIM;

  function automatic logic signed [SW-1:0] scale(input logic signed [SW-1:0] v, input longint k);
    logic signed [PW-1:0] p;
    p = PW'(v) * PW'(k) + (PW'(1) <<< (Q - 1));
    return SW'(p >>> Q);
  endfunction

  function automatic logic signed [DW-1:0] sat(input logic signed [SW-1:0] v);
    if (v > FS)  return FS[DW-1:0];
    if (v < NFS) return NFS[DW-1:0];
    return v[DW-1:0];
  endfunction

  logic signed [DW-1:0] w1, w2;
  logic signed [SW-1:0] xe, xc, fb, w1e, w2e, s1, s2;

  assign xe  = SW'(x_in);
  assign xc  = (xe > LIM) ? LIM : ((xe < NLIM) ? NLIM : xe);
  assign w1e = SW'(w1);
  assign w2e = SW'(w2);

  assign bit_out = (w2 > 0);
  assign fb      = bypass ? w2e : (bit_out ? FS : NFS);
  assign val_out = fb[DW-1:0];

  assign s1 = w1e + scale(xc, K5) - scale(fb, K5);
  assign s2 = w2e + scale(xc, K3) + scale(w1e, K3) - scale(fb, K6);

  always_ff @(posedge clk) begin
    if (rst) begin
      w1 <= '0;
      w2 <= '0;
    end else if (en) begin
      w1 <= sat(s1);
      w2 <= sat(s2);
    end
  end
endmodule

// File: rtl/sd2_modulator_chk.sv
module sd2_modulator_chk #(
  parameter int F = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              bypass,
  input logic              bit_out,
  input logic signed [F:0] w1,
  input logic signed [F:0] w2
);
  localparam logic signed [F:0] FS = {2'b01, {(F-1){1'b0}}};

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (w1 == 0 && w2 == 0));

  // R7
  w1_rail_chk: assert property (@(posedge clk) disable iff (rst) (w1 <= FS && w1 >= -FS));

  // R7
  w2_rail_chk: assert property (@(posedge clk) disable iff (rst) (w2 <= FS && w2 >= -FS));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst) !en |=> ($stable(w1) && $stable(w2)));

  // R4
  fb_high_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !bypass && bit_out) |=> (w1 <= $past(w1)));

  // R4
  fb_low_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !bypass && !bit_out) |=> (w1 >= $past(w1)));
endmodule

bind sd2_modulator sd2_modulator_chk #(.F(F)) u_chk (
  .clk(clk), .rst(rst), .en(en), .bypass(bypass), .bit_out(bit_out), .w1(w1), .w2(w2)
);

// File: tb/sd2_modulator_test.sv
module sd2_modulator_test;
  localparam int F = 20;
  localparam int Q = 18;
  localparam longint FS  = longint'(1) << (F - 1);
  localparam longint LIM = (FS * 4) / 5;
  localparam longint K5 = ((longint'(1) << (Q + 1)) + 5) / 10;
  localparam longint K3 = ((longint'(1) << (Q + 1)) + 3) / 6;
  localparam longint K6 = ((longint'(1) << (Q + 1)) + 6) / 12;

  typedef struct {
    logic   b;
    longint v;
    string  tag;
  } exp_t;

  logic clk = 0, rst = 1, en = 0, bypass = 0;
  logic signed [F:0] x_in = '0;
  logic bit_out;
  logic signed [F:0] val_out;

  int errors = 0, checks = 0, sat_hits = 0;
  bit done = 0, acc_on = 0;
  longint m1 = 0, m2 = 0, acc = 0, acc_n = 0;
  exp_t q[$];

  sd2_modulator #(.F(F), .Q(Q)) uut (
    .clk(clk), .rst(rst), .en(en), .bypass(bypass),
    .x_in(x_in), .bit_out(bit_out), .val_out(val_out)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sc(input longint v, input longint k);
    return (v * k + (longint'(1) << (Q - 1))) >>> Q;
  endfunction

  function automatic longint clip(input longint v);
    if (v > FS)  begin sat_hits++; return FS;  end
    if (v < -FS) begin sat_hits++; return -FS; end
    return v;
  endfunction

  task automatic step(input longint x, input logic b, input logic e, input string tag);
    longint xc, fb, n1, n2;
    exp_t it;
    @(negedge clk);
    x_in = x[F:0];
    bypass = b;
    en = e;
    if (e) begin
      xc = (x > LIM) ? LIM : ((x < -LIM) ? -LIM : x);
      fb = b ? m2 : ((m2 > 0) ? FS : -FS);
      n1 = m1 + sc(xc, K5) - sc(fb, K5);
      n2 = m2 + sc(xc, K3) + sc(m1, K3) - sc(fb, K6);
      m1 = clip(n1);
      m2 = clip(n2);
    end
    it.b = (m2 > 0);
    it.v = b ? m2 : ((m2 > 0) ? FS : -FS);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic do_reset();
    wait (q.size() == 0);
    @(negedge clk);
    rst = 1;
    en = 0;
    bypass = 0;
    repeat (2) @(negedge clk);
    m1 = 0;
    m2 = 0;
    rst = 0;
  endtask

  always begin
    exp_t it;
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      it = q.pop_front();
      check(bit_out == it.b, {it.tag, " bit"}, longint'(bit_out), longint'(it.b));
      check(longint'(val_out) == it.v, {it.tag, " val"}, longint'(val_out), it.v);
      if (acc_on) begin
        acc += longint'(val_out);
        acc_n++;
      end
    end
  end

  task automatic dc_run(input longint x);
    real mean, dev;
    do_reset();
    acc = 0;
    acc_n = 0;
    acc_on = 1;
    for (int i = 0; i < 49152; i++) step(x, 1'b0, 1'b1, "R10 R6 dc");
    wait (q.size() == 0);
    @(posedge clk);
    #3;
    acc_on = 0;
    mean = real'(acc) / real'(acc_n);
    dev = mean - real'(x);
    if (dev < 0.0) dev = -dev;
    check(dev <= real'(FS) / 4096.0, "R10 dc mean", longint'($rtoi(mean)), x);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1;
    check(bit_out == 1'b0, "R1 reset bit", longint'(bit_out), 0);
    check(longint'(val_out) == -FS, "R1 reset val", longint'(val_out), -FS);
    bypass = 1;
    #1;
    check(longint'(val_out) == 0, "R1 reset bypass val", longint'(val_out), 0);
    bypass = 0;

    for (int k = 0; k < 200; k++)
      step(longint'($rtoi(0.6 * real'(FS) * $sin(real'(k) * 0.05))), 1'b0, 1'b1, "R3 R4 R5 R6 sine");

    for (int k = 0; k < 50; k++) step((longint'(1) << F) - 1, 1'b0, 1'b1, "R2 over positive");
    for (int k = 0; k < 50; k++) step(-(longint'(1) << F), 1'b0, 1'b1, "R2 over negative");

    for (int k = 0; k < 60; k++) step(FS / 3, 1'b0, (k % 3) != 0, "R8 enable gaps");
    for (int k = 0; k < 10; k++) step(FS / 2, k[0], 1'b0, "R8 idle bypass toggle");

    do_reset();
    for (int k = 0; k < 480; k++)
      step(((k / 12) % 2 == 0) ? LIM : -LIM, 1'b1, 1'b1, "R9 R7 bypass square");
    for (int k = 0; k < 120; k++) step(FS / 4, 1'b1, 1'b1, "R9 bypass settle");
    wait (q.size() == 0);
    check(sat_hits > 0, "R7 saturation reached", longint'(sat_hits), 1);

    dc_run(FS / 2);
    dc_run(-(FS * 3) / 10);

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule